// File: doc/BRIEF.md
# Bidirectional Timer Counter Unit

This block is the counting core of an 8-bit timer. On each timer tick it either increments the count, decrements it, or clears it. The waveform mode input decides which. The tick comes from one of two places. The first is a 10-bit free-running prescaler of the system clock, with divide ratios 1, 8, 64, 256 or 1024. The second is an external pin: it is synchronized, edge-detected, and counted on the chosen edge. A clock select value of zero stops the counter.

Software can load the count at any time. A load always wins over the counting action of that cycle. The compare value comes in as an input. The block reports when the count sits at TOP and at BOTTOM, and it keeps an overflow flag. The flag is set at a point that depends on the mode and is cleared by a write of one. The compare unit, the output pin logic and the interrupt logic sit outside this block.

There is no data stream in this block, so every pin is a plain level or one-cycle strobe with no handshake.

Top module: `tmr_count_unit`

## Requirements
- R1: After reset the count is 0x00, the overflow flag is 0, at_bottom is 1, and the prescaler restarts from zero.
- R2: With clk_sel = 0 the count holds its value for any number of cycles, and a load through cnt_wr still updates it.
- R3: With clk_sel = 1 the timer ticks on every system clock cycle.
- R4: clk_sel = 2, 3, 4, 5 give one tick per 8, 64, 256, 1024 system cycles. Each tick falls on a cycle where the low 3, 6, 8 or 10 prescaler bits are all ones, so any window of k·N cycles holds exactly k ticks.
- R5: clk_sel = 6 counts falling edges and clk_sel = 7 counts rising edges of ext_pin. The pin passes through two synchronizer flops and an edge detector. The count changes on the third rising clock edge after the pin changes, and the opposite edge has no effect.
- R6: When cnt_wr is 1, the next count equals cnt_wdata whatever the tick and mode. That cycle neither advances the count nor sets the overflow flag.
- R7: wave_mode 0 (free run): the count increments and wraps 0xFF to 0x00. A tick at 0xFF sets the overflow flag.
- R8: wave_mode 1 (clear on compare): a tick while the count equals cmp_val loads 0x00, and other ticks increment. A tick at 0xFF sets the overflow flag. TOP is cmp_val.
- R9: wave_mode 2 (fast sequence): counts up with TOP fixed at 0xFF, wrapping to 0x00 and setting the overflow flag on a tick at 0xFF.
- R10: wave_mode 3 (up/down): the count rises to 0xFF and then falls to 0x00. A tick at 0x00 while falling turns it upward to 0x01 and sets the overflow flag. A load keeps the current direction, and any other mode resets the direction to up.
- R11: ovf_clr = 1 clears the overflow flag at the next edge. If the flag is set in that same cycle, the set wins.
- R12: at_top is 1 while the count equals TOP (cmp_val in mode 1, 0xFF otherwise), and at_bottom is 1 while the count is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| clk_sel | input | 3 | Tick source: 0 off, 1 clk, 2 /8, 3 /64, 4 /256, 5 /1024, 6 pin fall, 7 pin rise |
| wave_mode | input | 2 | Counting sequence: 0 free, 1 clear on compare, 2 fast, 3 up/down |
| cmp_val | input | 8 | Compare value, TOP in mode 1 |
| ext_pin | input | 1 | Asynchronous external count pin |
| cnt_wr | input | 1 | Load strobe for the count |
| cnt_wdata | input | 8 | Value loaded by cnt_wr |
| ovf_clr | input | 1 | Write-one-to-clear strobe for the overflow flag |
| cnt_q | output | 8 | Current count, readable at all times |
| ovf_flag | output | 1 | Overflow flag |
| at_top | output | 1 | Count equals TOP |
| at_bottom | output | 1 | Count equals 0x00 |
| tick | output | 1 | Timer tick of the current cycle |

## Verification
The assertions assume that cnt_wr and ovf_clr are one-cycle-clean levels sampled at the rising edge. They also assume that the mode and compare value are steady across any edge where a wrap or turn is checked. The stimulus meets this by changing every input only on the falling clock edge. ext_pin is also driven only on falling edges and held for several cycles between transitions, so each pin change produces exactly one synchronized edge. The prescaler checks count ticks over windows that are whole multiples of the divide ratio, which makes them independent of the prescaler phase.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

  typedef enum logic [1:0] {
    MODE_FREE    = 2'd0,
    MODE_CLR_CMP = 2'd1,
    MODE_FAST    = 2'd2,
    MODE_TRI     = 2'd3
  } tcu_mode_e;

  localparam logic [2:0] CS_OFF      = 3'd0;
  localparam logic [2:0] CS_DIV1     = 3'd1;
  localparam logic [2:0] CS_DIV8     = 3'd2;
  localparam logic [2:0] CS_DIV64    = 3'd3;
  localparam logic [2:0] CS_DIV256   = 3'd4;
  localparam logic [2:0] CS_DIV1024  = 3'd5;
  localparam logic [2:0] CS_EXT_FALL = 3'd6;
  localparam logic [2:0] CS_EXT_RISE = 3'd7;

  localparam int NUM_TAPS = 4;

endpackage

// File: rtl/tcu_prescaler.sv
module tcu_prescaler #(
  parameter int PRE_W = 10,
  parameter int SH_A  = 3,
  parameter int SH_B  = 6,
  parameter int SH_C  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  output logic [tcu_pkg::NUM_TAPS-1:0] tap
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  for (genvar g = 0; g < tcu_pkg::NUM_TAPS; g++) begin : g_tap
    localparam int SH = (g == 0) ? SH_A : (g == 1) ? SH_B : (g == 2) ? SH_C : PRE_W;
    assign tap[g] = &pre_q[SH-1:0];
  end

  // R4
  coarse_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap[tcu_pkg::NUM_TAPS-1] |-> (&tap));

endmodule

// File: rtl/tcu_edge_sync.sv
module tcu_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;

  // R5
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall}));

  // R5
  edge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise || fall) |=> !(rise || fall));

endmodule

// File: rtl/tcu_clk_select.sv
module tcu_clk_select (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [2:0]                   sel,
  input  logic [tcu_pkg::NUM_TAPS-1:0] tap,
  input  logic                         ext_rise,
  input  logic                         ext_fall,
  output logic                         tick
);
  import tcu_pkg::*;

  always_comb begin
    unique case (sel)
      CS_OFF:      tick = 1'b0;
      CS_DIV1:     tick = 1'b1;
      CS_DIV8:     tick = tap[0];
      CS_DIV64:    tick = tap[1];
      CS_DIV256:   tick = tap[2];
      CS_DIV1024:  tick = tap[3];
      CS_EXT_FALL: tick = ext_fall;
      default:     tick = ext_rise;
    endcase
  end

  // R2
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == CS_OFF) |-> !tick);

endmodule

// File: rtl/tcu_counter_core.sv
module tcu_counter_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [1:0]   mode_in,
  input  logic [W-1:0] cmp,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         ovf_clr,
  output logic [W-1:0] cnt,
  output logic         ovf,
  output logic         at_top,
  output logic         at_bottom
);
  import tcu_pkg::*;

  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] BOTV = {W{1'b0}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  tcu_mode_e    mode;
  logic         down_q, down_n;
  logic [W-1:0] cnt_n, top_val;
  logic         ovf_set;

  assign mode    = tcu_mode_e'(mode_in);
  assign top_val = (mode == MODE_CLR_CMP) ? cmp : MAXV;

  always_comb begin
    cnt_n   = cnt;
    down_n  = (mode == MODE_TRI) ? down_q : 1'b0;
    ovf_set = 1'b0;
    if (wr) begin
      cnt_n = wdata;
    end else if (tick) begin
      unique case (mode)
        MODE_FREE, MODE_FAST: begin
          cnt_n   = cnt + ONE;
          ovf_set = (cnt == MAXV);
        end
        MODE_CLR_CMP: begin
          cnt_n   = (cnt == cmp) ? BOTV : cnt + ONE;
          ovf_set = (cnt == MAXV);
        end
        default: begin
          if (!down_q) begin
            if (cnt == MAXV) begin
              cnt_n  = cnt - ONE;
              down_n = 1'b1;
            end else begin
              cnt_n = cnt + ONE;
            end
          end else begin
            if (cnt == BOTV) begin
              cnt_n   = cnt + ONE;
              down_n  = 1'b0;
              ovf_set = 1'b1;
            end else begin
              cnt_n = cnt - ONE;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= BOTV;
      down_q <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      cnt    <= cnt_n;
      down_q <= down_n;
      if (ovf_set)      ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

  assign at_top    = (cnt == top_val);
  assign at_bottom = (cnt == BOTV);

  // R6
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cnt == $past(wdata)));

  // R7
  free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr && mode == MODE_FREE && cnt == MAXV) |=> (cnt == BOTV && ovf));

  // R10
  tri_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr && mode == MODE_TRI && cnt == MAXV) |=> (cnt == MAXV - ONE));

  // R11
  ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !tick) |=> !ovf);

endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       clk_sel,
  input  logic [1:0]       wave_mode,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             ext_pin,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_flag,
  output logic             at_top,
  output logic             at_bottom,
  output logic             tick
);
  logic [tcu_pkg::NUM_TAPS-1:0] tap;
  logic ext_rise, ext_fall;

  tcu_prescaler #(.PRE_W(PRE_W), .SH_A(3), .SH_B(6), .SH_C(8)) u_pre (
    .clk(clk), .rst_n(rst_n), .tap(tap)
  );

  tcu_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise(ext_rise), .fall(ext_fall)
  );

  tcu_clk_select u_sel (
    .clk(clk), .rst_n(rst_n), .sel(clk_sel), .tap(tap),
    .ext_rise(ext_rise), .ext_fall(ext_fall), .tick(tick)
  );

  tcu_counter_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_in(wave_mode), .cmp(cmp_val),
    .wr(cnt_wr), .wdata(cnt_wdata), .ovf_clr(ovf_clr),
    .cnt(cnt_q), .ovf(ovf_flag), .at_top(at_top), .at_bottom(at_bottom)
  );

  // R2
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0 && !cnt_wr) |=> $stable(cnt_q));

  // R3
  every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd1) |-> tick);

endmodule

// File: tb/sim_tmr_count_unit.sv
`timescale 1ns/1ps
module sim_tmr_count_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] clk_sel;
  logic [1:0] wave_mode;
  logic [7:0] cmp_val;
  logic       ext_pin;
  logic       cnt_wr;
  logic [7:0] cnt_wdata;
  logic       ovf_clr;
  logic [7:0] cnt_q;
  logic       ovf_flag, at_top, at_bottom, tick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_count_unit u0 (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .wave_mode(wave_mode),
    .cmp_val(cmp_val), .ext_pin(ext_pin), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .ovf_clr(ovf_clr), .cnt_q(cnt_q), .ovf_flag(ovf_flag), .at_top(at_top),
    .at_bottom(at_bottom), .tick(tick)
  );

  // mode, cmp, start, cycles, expected count, expected flag
  localparam logic [34:0] VEC [7] = '{
    {2'd0, 8'h00, 8'h10, 8'd5, 8'h15, 1'b0},   // R7 plain count
    {2'd0, 8'h00, 8'hFD, 8'd5, 8'h02, 1'b1},   // R7 wrap
    {2'd1, 8'h20, 8'h1E, 8'd4, 8'h01, 1'b0},   // R8 clear at compare
    {2'd1, 8'hFF, 8'hFE, 8'd3, 8'h01, 1'b1},   // R8 compare at max
    {2'd2, 8'h00, 8'hFF, 8'd1, 8'h00, 1'b1},   // R9 wrap
    {2'd3, 8'h00, 8'hFD, 8'd4, 8'hFD, 1'b0},   // R10 turn at top
    {2'd3, 8'h00, 8'h02, 8'd4, 8'h02, 1'b1}    // R10 turn at bottom, still falling
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] v);
    clk_sel = 3'd0; cnt_wr = 1'b1; cnt_wdata = v; ovf_clr = 1'b1;
    @(negedge clk);
    cnt_wr = 1'b0; ovf_clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; clk_sel = 3'd0; wave_mode = 2'd0; cmp_val = 8'h00;
    ext_pin = 1'b0; cnt_wr = 1'b0; cnt_wdata = 8'h00; ovf_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 count", cnt_q, 8'h00);
    chk("R1 flag", ovf_flag, 0);
    chk("R1 at_bottom", at_bottom, 1);
    @(negedge clk);

    // table walk: R3 with every cycle ticking
    foreach (VEC[i]) begin
      wave_mode = VEC[i][34:33];
      cmp_val   = VEC[i][32:25];
      load(VEC[i][24:17]);
      clk_sel = 3'd1;
      repeat (int'(VEC[i][16:9])) @(negedge clk);
      clk_sel = 3'd0;
      chk($sformatf("R3 vec%0d count", i), cnt_q, VEC[i][8:1]);
      chk($sformatf("R7-table vec%0d flag", i), ovf_flag, VEC[i][0]);
    end

    // R2 stopped: count holds, load still works
    wave_mode = 2'd0;
    load(8'h33);
    repeat (10) @(negedge clk);
    chk("R2 hold", cnt_q, 8'h33);

    // R6 load wins over a running tick, and blocks the flag at 0xFF
    load(8'hFF);
    clk_sel = 3'd1; cnt_wr = 1'b1; cnt_wdata = 8'hFF;
    @(negedge clk);
    cnt_wr = 1'b0;
    chk("R6 load priority", cnt_q, 8'hFF);
    chk("R6 no flag", ovf_flag, 0);
    cnt_wr = 1'b1; cnt_wdata = 8'h50;
    @(negedge clk);
    cnt_wr = 1'b0;
    chk("R6 load running", cnt_q, 8'h50);
    @(negedge clk);
    clk_sel = 3'd0;
    chk("R6 resumes", cnt_q, 8'h51);

    // R11 set wins over a clear in the same cycle, clear alone works
    load(8'hFF);
    clk_sel = 3'd1; ovf_clr = 1'b1;
    @(negedge clk);
    clk_sel = 3'd0; ovf_clr = 1'b0;
    chk("R11 set wins", ovf_flag, 1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    chk("R11 clear", ovf_flag, 0);

    // R4 prescaled rates
    load(8'h00); clk_sel = 3'd2; repeat (64)   @(negedge clk); clk_sel = 3'd0;
    chk("R4 div8", cnt_q, 8);
    load(8'h00); clk_sel = 3'd3; repeat (256)  @(negedge clk); clk_sel = 3'd0;
    chk("R4 div64", cnt_q, 4);
    load(8'h00); clk_sel = 3'd4; repeat (1024) @(negedge clk); clk_sel = 3'd0;
    chk("R4 div256", cnt_q, 4);
    load(8'h00); clk_sel = 3'd5; repeat (2048) @(negedge clk); clk_sel = 3'd0;
    chk("R4 div1024", cnt_q, 2);

    // R5 external rising edge, three-edge latency
    load(8'h00);
    clk_sel = 3'd7;
    repeat (4) @(negedge clk);
    ext_pin = 1'b1;
    @(negedge clk); chk("R5 latency1", cnt_q, 0);
    @(negedge clk); chk("R5 latency2", cnt_q, 0);
    @(negedge clk); chk("R5 latency3", cnt_q, 1);
    repeat (3) @(negedge clk);
    ext_pin = 1'b0;
    repeat (5) @(negedge clk);
    chk("R5 fall ignored in rise mode", cnt_q, 1);
    clk_sel = 3'd6;
    ext_pin = 1'b1;
    repeat (5) @(negedge clk);
    chk("R5 rise ignored in fall mode", cnt_q, 1);
    ext_pin = 1'b0;
    repeat (5) @(negedge clk);
    chk("R5 fall counted", cnt_q, 2);
    clk_sel = 3'd0;

    // R12 TOP and BOTTOM indications per mode
    wave_mode = 2'd1; cmp_val = 8'h40;
    load(8'h40);
    chk("R12 top at compare", at_top, 1);
    wave_mode = 2'd0;
    @(negedge clk);
    chk("R12 no top below max", at_top, 0);
    load(8'hFF);
    chk("R12 top at max", at_top, 1);
    chk("R12 not bottom", at_bottom, 0);

    finish_run();
  end
endmodule